// File: doc/BRIEF.md
# Preset-Offset Decade Frequency Count Register

This block is the counting core of a frequency readout that shows a received frequency instead of the raw local oscillator frequency. A chain of BCD decades counts gated input pulses. Before each counting interval the displayed decades are loaded with the ten's complement of a fixed offset, taken from a programmable BCD preset. The count therefore rolls past all-nines, the carry out of the top decade is dropped, and the offset is subtracted with no subtractor. With a preset of 99545, the first 455 displayed increments return the chain to 00000, and it then counts upward from there.

A hidden decade sits ahead of the displayed chain and divides by ten. It is reloaded with 5 rather than 0, so the last shown digit is rounded to nearest instead of truncated. An offset-enable input forces every preset digit to zero, which turns the block into a plain frequency meter. A strobe, issued after the gate closes and before the next load, copies the displayed decades into a display register that holds steady while the next interval counts.

The surrounding sequencer drives gate, strobe and load in that order once per measurement. Input pulses arrive as single-cycle enables that are already synchronous to the system clock.

Top module: `offset_count_reg`

## Requirements
- R1: While reset is high, the display register, every displayed decade and the hidden decade are cleared to zero, so `disp_bcd` reads 0 on the cycle after reset.
- R2: A load with the offset enabled puts the preset into the displayed decades and puts 5 into the hidden decade. Digit k of the preset and of `disp_bcd` sits at bits [4k+3:4k], and digit 0 is the least significant.
- R3: A load with the offset disabled puts zero into every displayed decade, whatever the preset holds, so the chain reads the raw pulse count.
- R4: On load, a preset digit above 9 is taken as 9, and no decade ever holds a code above 9.
- R5: A pulse is counted only in a cycle where `gate` and `pulse_en` are both high. In any other cycle without a load, all decades keep their values.
- R6: The hidden decade divides by ten. After a load with offset enabled, N counted pulses make the display read (preset + floor((N+5)/10)) mod 100000.
- R7: The carry out of the most significant decade is discarded, so 99999 plus one displayed step gives 00000.
- R8: A strobe copies the displayed decades, as they were before that clock edge, into the display register. Without a strobe, `disp_bcd` does not change.
- R9: When load and a counted pulse fall in the same cycle, the load wins and the pulse is lost.
- R10: A strobe in the same cycle as a load or a counted pulse captures the value from before that cycle's load or increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_en | input | 1 | Single-cycle enable, one per input event |
| gate | input | 1 | Counting window; pulses count only while high |
| strobe | input | 1 | Copies the displayed decades into the display register |
| load | input | 1 | Reloads the displayed decades from the preset and the hidden decade with 5 |
| offset_en | input | 1 | When low, the preset is replaced with zero on load |
| preset_bcd | input | 20 | BCD preset, digit k at bits [4k+3:4k] |
| disp_bcd | output | 20 | Latched BCD display, digit k at bits [4k+3:4k] |

## Verification
Two collisions matter. A load can coincide with a counted pulse, and a strobe can coincide with either a load or a pulse that rolls the hidden decade over. The bench provokes the first by holding load together with gate and pulse enable, then giving exactly four pulses. Only a correct priority leaves the display on the preset, because a counted pulse would have pushed the hidden decade past its rollover. It provokes the second by strobing in the load cycle and in the rollover cycle. It expects the value from before the edge, then the new value on the following strobe, and a behavioural model compares the display on every clock.

// File: rtl/offset_count_pkg.sv
`timescale 1ns/1ps
package offset_count_pkg;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_TOP = 4'd9;

    // per-cycle control bundle seen by the datapath
    typedef struct packed {
        logic reload;
        logic tick;
        logic capture;
    } ctrl_t;

    function automatic logic bcd_is_top(input bcd_t d);
        return d == BCD_TOP;
    endfunction

    function automatic bcd_t bcd_clamp(input bcd_t d);
        return (d > BCD_TOP) ? BCD_TOP : d;
    endfunction

    function automatic bcd_t bcd_next(input bcd_t d);
        return bcd_is_top(d) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/bcd_decade.sv
`timescale 1ns/1ps
module bcd_decade
    import offset_count_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  bcd_t load_val,
    input  logic step,
    output bcd_t q
);

    bcd_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= load_val;
        end else if (step) begin
            q_r <= bcd_next(q_r);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/decade_chain.sv
`timescale 1ns/1ps
module decade_chain
    import offset_count_pkg::*;
#(
    parameter int NUM_DIGITS    = 5,
    parameter int PRESCALE_INIT = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    offset_en,
    input  logic                    tick,
    input  logic [NUM_DIGITS*4-1:0] preset_flat,
    output logic [NUM_DIGITS*4-1:0] count_flat,
    output bcd_t                    pre_q
);

    localparam bcd_t PRE_INIT = bcd_t'(PRESCALE_INIT);

    logic [NUM_DIGITS-1:0] step;
    bcd_t                  pre_val;

    bcd_decade u_prescale (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (PRE_INIT),
        .step     (tick),
        .q        (pre_val)
    );

    // ripple enable: a decade advances when every stage below it wraps
    always_comb begin
        logic run;
        run = tick && bcd_is_top(pre_val);
        for (int i = 0; i < NUM_DIGITS; i++) begin
            step[i] = run;
            run     = run && bcd_is_top(count_flat[i*4 +: 4]);
        end
    end

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        bcd_t lv;
        bcd_t q;
        assign lv = offset_en ? bcd_clamp(preset_flat[i*4 +: 4]) : '0;
        bcd_decade u_dec (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (lv),
            .step     (step[i]),
            .q        (q)
        );
        assign count_flat[i*4 +: 4] = q;
    end

    assign pre_q = pre_val;

endmodule

// File: rtl/display_latch.sv
`timescale 1ns/1ps
module display_latch #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (capture) begin
            q <= d;
        end
    end

endmodule

// File: rtl/offset_count_reg.sv
`timescale 1ns/1ps
module offset_count_reg
    import offset_count_pkg::*;
#(
    parameter int NUM_DIGITS    = 5,
    parameter int PRESCALE_INIT = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pulse_en,
    input  logic                    gate,
    input  logic                    strobe,
    input  logic                    load,
    input  logic                    offset_en,
    input  logic [NUM_DIGITS*4-1:0] preset_bcd,
    output logic [NUM_DIGITS*4-1:0] disp_bcd
);

    localparam int W = NUM_DIGITS * 4;

    ctrl_t          ctl;
    logic [W-1:0]   count_q;
    bcd_t           pre_q;

    always_comb begin
        ctl.reload  = load;
        ctl.tick    = gate && pulse_en;
        ctl.capture = strobe;
    end

    decade_chain #(
        .NUM_DIGITS    (NUM_DIGITS),
        .PRESCALE_INIT (PRESCALE_INIT)
    ) u_chain (
        .clk         (clk),
        .rst         (rst),
        .load        (ctl.reload),
        .offset_en   (offset_en),
        .tick        (ctl.tick),
        .preset_flat (preset_bcd),
        .count_flat  (count_q),
        .pre_q       (pre_q)
    );

    display_latch #(
        .WIDTH (W)
    ) u_disp (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.capture),
        .d       (count_q),
        .q       (disp_bcd)
    );

endmodule

// File: rtl/offset_count_chk.sv
`timescale 1ns/1ps
module offset_count_chk
    import offset_count_pkg::*;
#(
    parameter int NUM_DIGITS    = 5,
    parameter int PRESCALE_INIT = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pulse_en,
    input logic                    gate,
    input logic                    strobe,
    input logic                    load,
    input logic                    offset_en,
    input logic [NUM_DIGITS*4-1:0] disp_bcd,
    input logic [NUM_DIGITS*4-1:0] count_q,
    input bcd_t                    pre_q
);

    function automatic logic all_legal(input logic [NUM_DIGITS*4-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    localparam logic [NUM_DIGITS*4-1:0] ALL_NINES = {NUM_DIGITS{4'd9}};

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(disp_bcd));                                   // R8
    AST_STROBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> disp_bcd == $past(count_q));                            // R10
    AST_LOAD_PRESCALE: assert property (@(posedge clk) disable iff (rst)
        load |=> pre_q == bcd_t'(PRESCALE_INIT));                          // R2
    AST_LOAD_NO_OFFSET: assert property (@(posedge clk) disable iff (rst)
        load && !offset_en |=> count_q == '0);                             // R3
    AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        all_legal(count_q) && pre_q <= 4'd9);                              // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load && !(gate && pulse_en) |=> $stable(count_q) && $stable(pre_q)); // R5
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        !load && gate && pulse_en && pre_q == 4'd9 && count_q == ALL_NINES
        |=> count_q == '0);                                                // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load && gate && pulse_en |=> pre_q == bcd_t'(PRESCALE_INIT));      // R9

endmodule

bind offset_count_reg offset_count_chk #(
    .NUM_DIGITS    (NUM_DIGITS),
    .PRESCALE_INIT (PRESCALE_INIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_en  (pulse_en),
    .gate      (gate),
    .strobe    (strobe),
    .load      (load),
    .offset_en (offset_en),
    .disp_bcd  (disp_bcd),
    .count_q   (count_q),
    .pre_q     (pre_q)
);

// File: tb/offset_count_reg_tb.sv
`timescale 1ns/1ps
module offset_count_reg_tb_top;

    localparam int ND = 5;
    localparam int W  = ND * 4;
    localparam int MODULUS = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pulse_en = 1'b0;
    logic         gate = 1'b0;
    logic         strobe = 1'b0;
    logic         load = 1'b0;
    logic         offset_en = 1'b1;
    logic [W-1:0] preset_bcd = '0;
    logic [W-1:0] disp_bcd;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int m_cnt = 0;
    int m_pre = 0;
    int m_disp = 0;

    always #2.5 clk = ~clk;

    offset_count_reg dut_i (
        .clk        (clk),
        .rst        (rst),
        .pulse_en   (pulse_en),
        .gate       (gate),
        .strobe     (strobe),
        .load       (load),
        .offset_en  (offset_en),
        .preset_bcd (preset_bcd),
        .disp_bcd   (disp_bcd)
    );

    function automatic int preset_value(input logic [W-1:0] p);
        int v = 0;
        int scale = 1;
        for (int i = 0; i < ND; i++) begin
            int d = int'(p[i*4 +: 4]);
            if (d > 9) d = 9;
            v += d * scale;
            scale *= 10;
        end
        return v;
    endfunction

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r = '0;
        int x = v;
        for (int i = 0; i < ND; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // behavioural reference, updated with the values seen at each edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= 0;
            m_pre  <= 0;
            m_disp <= 0;
        end else begin
            if (strobe) m_disp <= m_cnt;
            if (load) begin
                m_cnt <= offset_en ? preset_value(preset_bcd) : 0;
                m_pre <= 5;
            end else if (gate && pulse_en) begin
                if (m_pre == 9) begin
                    m_pre <= 0;
                    m_cnt <= (m_cnt + 1) % MODULUS;
                end else begin
                    m_pre <= m_pre + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (disp_bcd !== to_bcd(m_disp)) begin
                n_errors++;
                $display("FAIL R8 per-cycle model: got %h expected %h", disp_bcd, to_bcd(m_disp));
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic g, input logic p, input logic s, input logic l);
        @(negedge clk);
        gate = g; pulse_en = p; strobe = s; load = l;
    endtask

    task automatic do_load(input logic [W-1:0] pv, input logic oe);
        @(negedge clk);
        preset_bcd = pv; offset_en = oe;
        gate = 0; pulse_en = 0; strobe = 0; load = 1;
    endtask

    task automatic count_pulses(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic show();
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset display", disp_bcd, '0);
        show();
        check("R1 reset count", disp_bcd, '0);

        // R6 rounding edge: 4544 pulses stays one step short of wrap
        do_load(20'h99545, 1); count_pulses(4544); show();
        check("R6 rounding below half", disp_bcd, 20'h99999);
        // R7 wrap to zero after 4545 pulses
        do_load(20'h99545, 1); count_pulses(4545); show();
        check("R7 offset subtract wraps", disp_bcd, 20'h00000);
        // R2 longer interval
        do_load(20'h99545, 1); count_pulses(16890); show();
        check("R2 offset reading", disp_bcd, 20'h01234);
        // R3 bypass
        do_load(20'h99545, 0); count_pulses(123); show();
        check("R3 offset disabled", disp_bcd, 20'h00012);
        // R4 clamp
        do_load(20'hF0A03, 1); step(0, 0, 0, 0); show();
        check("R4 clamp illegal digits", disp_bcd, 20'h90903);
        // R7 top wrap from all nines
        do_load(20'h99999, 1); count_pulses(5); show();
        check("R7 top carry dropped", disp_bcd, 20'h00000);

        // R5 ignored pulses
        do_load(20'h00000, 1);
        for (int i = 0; i < 50; i++) step(0, 1, 0, 0);
        for (int i = 0; i < 50; i++) step(1, 0, 0, 0);
        step(0, 0, 0, 0); show();
        check("R5 ungated pulses ignored", disp_bcd, 20'h00000);
        count_pulses(15); show();
        check("R5 gated pulses counted", disp_bcd, 20'h00002);

        // R9 load beats a counted pulse
        do_load(20'h00000, 1);
        step(1, 1, 0, 1); step(1, 1, 0, 1); step(1, 1, 0, 1);
        count_pulses(4); show();
        check("R9 load priority", disp_bcd, 20'h00000);

        // R10 strobe with load
        do_load(20'h12345, 1); count_pulses(25);
        @(negedge clk);
        preset_bcd = 20'h00700; strobe = 1; load = 1;
        step(0, 0, 0, 0);
        check("R10 strobe with load keeps old", disp_bcd, 20'h12348);
        show();
        check("R10 following strobe shows preset", disp_bcd, 20'h00700);

        // R10 strobe with rollover pulse
        do_load(20'h00000, 1); count_pulses(4);
        step(1, 1, 1, 0); step(0, 0, 0, 0);
        check("R10 strobe with pulse keeps old", disp_bcd, 20'h00000);
        show();
        check("R8 next strobe shows increment", disp_bcd, 20'h00001);

        // R8 display holds while counting proceeds
        count_pulses(30);
        check("R8 display holds without strobe", disp_bcd, 20'h00001);

        finish_run();
    end

endmodule